// File: doc/BRIEF.md
# Software Write-Protect Unlock Gate

This block sits in front of the page write engine of a parallel non-volatile memory. It watches every latched write, given as an address and data byte qualified by a strobe, and decides whether that write may reach the page buffer. Protection is armed out of reset. Page data is accepted only after a fixed three-write key: data AAh at 1555h, then 55h at 0AAAh, then A0h at 1555h. The key writes themselves are removed from the data path, so the key addresses remain ordinary storage locations.

One unlock covers exactly one programming cycle. After the key, data bytes on a single page are passed on with a store qualifier. The load phase ends when the byte-load window runs out, or when a write targets a different page. In either case the write timer is started and the gate waits for the engine's end-of-cycle pulse, then re-arms protection. A write that arrives without a valid key still starts the write timer, so the device is busy for a full cycle, but no data is stored. Between consecutive writes of the key and of the page load, at most `BLC_CYCLES` clock cycles may pass.

Top module: `swp_unlock_gate`

## Requirements
- R1: After reset, `protected_o` is 1 and `store_o` and `start_timer_o` are 0.
- R2: The three key writes (AAh at 1555h, 55h at 0AAAh, A0h at 1555h, in that order) never raise `store_o` or `start_timer_o`. `protected_o` falls in the cycle after the third key write is sampled.
- R3: While unlocked, a write on the page of the first loaded byte raises `store_o` for one cycle, in the cycle after the strobe. `store_addr_o` and `store_data_o` then show that write's address and data. The page is address bits [ADDR_W-1:6] for 64-byte pages.
- R4: A write in the idle locked state that is not the first key write raises `start_timer_o` for one cycle in the following cycle, with no `store_o`. The gate then stays busy: writes are ignored (no store, no timer) until `cycle_done`.
- R5: A write during the key sequence that does not match the expected step is treated as the unauthorised write of R4.
- R6: If no write arrives within `BLC_CYCLES` cycles of a key write, the sequence returns to idle with no timer start. A later full key then unlocks normally.
- R7: If the byte-load window expires after at least one data byte was loaded, `start_timer_o` pulses and `protected_o` returns to 1 in that same cycle.
- R8: If the window expires after the key with no data byte loaded, the gate returns to idle and `protected_o` returns to 1, with no timer start.
- R9: While unlocked, a write to a page other than the first loaded byte's page is not stored and starts the timer.
- R10: After `cycle_done` ends a programming cycle, protection is armed again: a data write without a new key is unauthorised.
- R11: A write that arrives exactly `BLC_CYCLES` cycles after the previous accepted write is still accepted.
- R12: `cycle_done` outside the busy state has no effect. For example, a pulse during the load phase neither ends the load nor stops later same-page writes from being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Latched write present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| cycle_done | input | 1 | End of programming cycle pulse from the engine |
| store_o | output | 1 | Previous-cycle write is to be stored |
| store_addr_o | output | ADDR_W | Address of the qualified write |
| store_data_o | output | DATA_W | Data of the qualified write |
| start_timer_o | output | 1 | One-cycle pulse starting the programming timer |
| protected_o | output | 1 | 1 while page loads are blocked |

## Verification
The bench builds the gate with 13-bit addresses, 64-byte pages and `BLC_CYCLES` set to 8. A short window lets expiry during the key and during the load, and the exact-limit arrival of R11, be reached within a few cycles of each write. Page crossings are exercised by flipping bits above address bit 5 while the 64-byte page keeps the key addresses on different pages. Engine end-of-cycle pulses are injected at random, so they land in idle, key and load states as well as in the busy state.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_KEY1 = 3'd1,
        ST_KEY2 = 3'd2,
        ST_LOAD = 3'd3,
        ST_BUSY = 3'd4
    } swp_state_e;

    localparam int KEY_STEPS = 3;

    localparam logic [15:0] KEY_ADDR_ODD  = 16'h1555;
    localparam logic [15:0] KEY_ADDR_EVEN = 16'h0AAA;

    typedef struct packed {
        logic store;
        logic start;
    } swp_act_t;

    // Address expected at each step of the unlock key
    function automatic logic [15:0] key_addr(input int step);
        return (step == 1) ? KEY_ADDR_EVEN : KEY_ADDR_ODD;
    endfunction

    // Data expected at each step of the unlock key
    function automatic logic [7:0] key_data(input int step);
        case (step)
            0:       return 8'hAA;
            1:       return 8'h55;
            default: return 8'hA0;
        endcase
    endfunction

    // States in which the byte-load window is running
    function automatic logic window_open(input swp_state_e s);
        return (s == ST_KEY1) || (s == ST_KEY2) || (s == ST_LOAD);
    endfunction

endpackage

// File: rtl/swp_key_match.sv
module swp_key_match
    import swp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    output logic [KEY_STEPS-1:0] hit
);

    for (genvar i = 0; i < KEY_STEPS; i++) begin : g_step
        localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(key_addr(i));
        localparam logic [DATA_W-1:0] STEP_DATA = DATA_W'(key_data(i));
        assign hit[i] = (addr == STEP_ADDR) && (data == STEP_DATA);
    end

endmodule

// File: rtl/swp_gap_timer.sv
module swp_gap_timer #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic expire
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fires on the LIMIT-th edge after the last write if no write comes then
    assign expire = run && !restart && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/swp_page_track.sv
module swp_page_track #(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [PAGE_W-1:0] page_in,
    output logic              same_page
);

    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (capture) begin
            page_q <= page_in;
        end
    end

    assign same_page = (page_in == page_q);

endmodule

// File: rtl/swp_unlock_fsm.sv
module swp_unlock_fsm
    import swp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_stb,
    input  logic [KEY_STEPS-1:0] key_hit,
    input  logic                 same_page,
    input  logic                 gap_expired,
    input  logic                 cycle_done,
    output swp_state_e           state_q,
    output swp_act_t             act_q,
    output logic                 page_capture
);

    swp_state_e state_d;
    swp_act_t   act_d;
    logic       loaded_q;
    logic       loaded_d;

    always_comb begin
        state_d      = state_q;
        act_d        = '0;
        loaded_d     = loaded_q;
        page_capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_stb) begin
                    if (key_hit[0]) begin
                        state_d = ST_KEY1;
                    end else begin
                        state_d     = ST_BUSY;
                        act_d.start = 1'b1;
                    end
                end
            end
            ST_KEY1: begin
                if (wr_stb) begin
                    if (key_hit[1]) begin
                        state_d = ST_KEY2;
                    end else begin
                        state_d     = ST_BUSY;
                        act_d.start = 1'b1;
                    end
                end else if (gap_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_KEY2: begin
                if (wr_stb) begin
                    if (key_hit[2]) begin
                        state_d  = ST_LOAD;
                        loaded_d = 1'b0;
                    end else begin
                        state_d     = ST_BUSY;
                        act_d.start = 1'b1;
                    end
                end else if (gap_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LOAD: begin
                if (wr_stb) begin
                    if (!loaded_q) begin
                        act_d.store  = 1'b1;
                        page_capture = 1'b1;
                        loaded_d     = 1'b1;
                    end else if (same_page) begin
                        act_d.store = 1'b1;
                    end else begin
                        state_d     = ST_BUSY;
                        act_d.start = 1'b1;
                    end
                end else if (gap_expired) begin
                    if (loaded_q) begin
                        state_d     = ST_BUSY;
                        act_d.start = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BUSY: begin
                if (cycle_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            act_q    <= '0;
            loaded_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            act_q    <= act_d;
            loaded_q <= loaded_d;
        end
    end

endmodule

// File: rtl/swp_unlock_gate.sv
module swp_unlock_gate
    import swp_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int BLC_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_done,
    output logic              store_o,
    output logic [ADDR_W-1:0] store_addr_o,
    output logic [DATA_W-1:0] store_data_o,
    output logic              start_timer_o,
    output logic              protected_o
);

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic [KEY_STEPS-1:0] key_hit;
    logic                 same_page;
    logic                 gap_expired;
    logic                 page_capture;
    swp_state_e           state_q;
    swp_act_t             act_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    data_q;

    swp_key_match #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_key (
        .addr(wr_addr),
        .data(wr_data),
        .hit (key_hit)
    );

    swp_gap_timer #(
        .LIMIT(BLC_CYCLES)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .run    (window_open(state_q)),
        .restart(wr_stb),
        .expire (gap_expired)
    );

    swp_page_track #(
        .PAGE_W(PAGE_W)
    ) u_page (
        .clk      (clk),
        .rst      (rst),
        .capture  (page_capture),
        .page_in  (wr_addr[ADDR_W-1:OFS_W]),
        .same_page(same_page)
    );

    swp_unlock_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .key_hit     (key_hit),
        .same_page   (same_page),
        .gap_expired (gap_expired),
        .cycle_done  (cycle_done),
        .state_q     (state_q),
        .act_q       (act_q),
        .page_capture(page_capture)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_stb) begin
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end

    assign store_o       = act_q.store;
    assign start_timer_o = act_q.start;
    assign store_addr_o  = addr_q;
    assign store_data_o  = data_q;
    assign protected_o   = (state_q != ST_LOAD);

endmodule

// File: rtl/swp_unlock_gate_chk.sv
module swp_unlock_gate_chk
    import swp_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              store_o,
    input logic [ADDR_W-1:0] store_addr_o,
    input logic [DATA_W-1:0] store_data_o,
    input logic              start_timer_o,
    input logic              protected_o,
    input swp_state_e        state_q
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!store_o && !start_timer_o));

    p_unlock_on_write_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(protected_o) |-> $past(wr_stb));

    p_store_needs_unlock_r3: assert property (@(posedge clk) disable iff (rst)
        store_o |-> $past(!protected_o));

    p_store_echo_r3: assert property (@(posedge clk) disable iff (rst)
        store_o |-> ($past(wr_stb) && store_addr_o == $past(wr_addr)
                     && store_data_o == $past(wr_data)));

    p_store_xor_start_r4: assert property (@(posedge clk) disable iff (rst)
        !(store_o && start_timer_o));

    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        start_timer_o |=> !start_timer_o);

    p_busy_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $past(state_q == ST_BUSY) |-> (!store_o && !start_timer_o));

    p_start_rearms_r7: assert property (@(posedge clk) disable iff (rst)
        start_timer_o |-> protected_o);

endmodule

bind swp_unlock_gate swp_unlock_gate_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_stb       (wr_stb),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .store_o      (store_o),
    .store_addr_o (store_addr_o),
    .store_data_o (store_data_o),
    .start_timer_o(start_timer_o),
    .protected_o  (protected_o),
    .state_q      (state_q)
);

// File: tb/tb_swp_unlock_gate.sv
`timescale 1ns/1ps
module tb_swp_unlock_gate;

    localparam int BLC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  data = '0;
    logic        done = 1'b0;
    logic        store_o, start_timer_o, protected_o;
    logic [12:0] store_addr_o;
    logic [7:0]  store_data_o;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    swp_unlock_gate #(
        .ADDR_W(13), .DATA_W(8), .PAGE_BYTES(64), .BLC_CYCLES(BLC)
    ) dut (
        .clk(clk), .rst(rst), .wr_stb(stb), .wr_addr(addr), .wr_data(data),
        .cycle_done(done), .store_o(store_o), .store_addr_o(store_addr_o),
        .store_data_o(store_data_o), .start_timer_o(start_timer_o),
        .protected_o(protected_o)
    );

    // Reference model: 0 idle, 1 key1 seen, 2 key2 seen, 3 loading, 4 busy
    int          m_st = 0;
    int          m_gap = 0;
    bit          m_loaded = 0;
    logic [6:0]  m_page = '0;
    bit          m_store = 0, m_start = 0;
    logic [12:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    function automatic bit key_ok(input int step, input logic [12:0] a, input logic [7:0] d);
        case (step)
            0:       return a == 13'h1555 && d == 8'hAA;
            1:       return a == 13'h0AAA && d == 8'h55;
            default: return a == 13'h1555 && d == 8'hA0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0; m_gap <= 0; m_loaded <= 0; m_store <= 0; m_start <= 0;
        end else begin
            m_store <= 0;
            m_start <= 0;
            if (stb) begin m_addr <= addr; m_data <= data; end
            case (m_st)
                0: if (stb) begin
                    if (key_ok(0, addr, data)) begin m_st <= 1; m_gap <= 0; end
                    else begin m_st <= 4; m_start <= 1; end
                end
                1, 2: if (stb) begin
                    if (key_ok(m_st, addr, data)) begin
                        m_st <= m_st + 1; m_gap <= 0; m_loaded <= 0;
                    end else begin m_st <= 4; m_start <= 1; end
                end else if (m_gap + 1 == BLC) m_st <= 0;
                else m_gap <= m_gap + 1;
                3: if (stb) begin
                    if (!m_loaded) begin
                        m_store <= 1; m_loaded <= 1; m_page <= addr[12:6]; m_gap <= 0;
                    end else if (addr[12:6] == m_page) begin
                        m_store <= 1; m_gap <= 0;
                    end else begin m_st <= 4; m_start <= 1; end
                end else if (m_gap + 1 == BLC) begin
                    if (m_loaded) begin m_st <= 4; m_start <= 1; end
                    else m_st <= 0;
                end else m_gap <= m_gap + 1;
                default: if (done) m_st <= 0;
            endcase
        end
    end

    task automatic compare();
        bit ok;
        ok = (store_o == m_store) && (start_timer_o == m_start)
             && (protected_o == (m_st != 3))
             && (!m_store || (store_addr_o == m_addr && store_data_o == m_data));
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s t=%0t: store=%0b start=%0b prot=%0b addr=%h data=%h expected store=%0b start=%0b prot=%0b addr=%h data=%h",
                     cur_req, $time, store_o, start_timer_o, protected_o, store_addr_o, store_data_o,
                     m_store, m_start, (m_st != 3), m_addr, m_data);
        end
    endtask

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s t=%0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic tick(input bit s, input logic [12:0] a, input logic [7:0] d, input bit dn);
        @(negedge clk);
        compare();
        stb = s; addr = a; data = d; done = dn;
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        tick(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, '0, 1'b0);
    endtask

    task automatic pulse_done();
        tick(1'b0, '0, '0, 1'b1);
    endtask

    // Writes are g edges apart (g=1 means back to back)
    task automatic unlock(input int g);
        wr(13'h1555, 8'hAA); idle(g - 1);
        wr(13'h0AAA, 8'h55); idle(g - 1);
        wr(13'h1555, 8'hA0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(protected_o == 1'b1, "R1", protected_o, 1);
        chk(store_o == 1'b0 && start_timer_o == 1'b0, "R1", store_o + start_timer_o, 0);
        rst = 1'b0;
        idle(2);

        // R2 and R3: unlock, then load three bytes on one page
        cur_req = "R2";
        unlock(1);
        idle(1);
        chk(protected_o == 1'b0, "R2", protected_o, 0);
        cur_req = "R3";
        wr(13'h0240, 8'h11); wr(13'h0255, 8'h22); wr(13'h027F, 8'h33);
        idle(1);
        chk(store_o == 1'b1 && store_data_o == 8'h33, "R3", store_data_o, 8'h33);
        // R7: window expiry after data starts the timer
        cur_req = "R7";
        idle(BLC);
        chk(protected_o == 1'b1, "R7", protected_o, 1);
        // R4: writes while busy are ignored
        cur_req = "R4";
        wr(13'h0100, 8'h5A); idle(2); pulse_done(); idle(1);
        // R10: protection re-armed after the cycle
        cur_req = "R10";
        wr(13'h0240, 8'h77); idle(1);
        chk(start_timer_o == 1'b1 && store_o == 1'b0, "R10", start_timer_o, 1);
        pulse_done(); idle(1);
        // R5: wrong second key step
        cur_req = "R5";
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h56); idle(1);
        chk(start_timer_o == 1'b1, "R5", start_timer_o, 1);
        pulse_done();
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1554, 8'hA0); idle(2);
        pulse_done(); idle(1);
        // R6: expiry during the key, then a clean unlock
        cur_req = "R6";
        wr(13'h1555, 8'hAA); idle(BLC + 1);
        chk(start_timer_o == 1'b0, "R6", start_timer_o, 0);
        unlock(2); wr(13'h1555, 8'h99); idle(BLC + 1); pulse_done();
        // R8: unlocked but nothing loaded
        cur_req = "R8";
        unlock(1); idle(BLC + 1);
        chk(protected_o == 1'b1 && start_timer_o == 1'b0, "R8", protected_o, 1);
        // R9: page change ends the load
        cur_req = "R9";
        unlock(1); wr(13'h0000, 8'h01); wr(13'h0140, 8'h02); idle(1);
        chk(store_o == 1'b0 && start_timer_o == 1'b1, "R9", store_o, 0);
        pulse_done(); idle(1);
        // R11: writes exactly BLC edges apart are still accepted
        cur_req = "R11";
        unlock(BLC); idle(BLC - 1); wr(13'h0A00, 8'hC3); idle(BLC - 1); wr(13'h0A01, 8'h3C);
        idle(1);
        chk(store_o == 1'b1 && store_data_o == 8'h3C, "R11", store_data_o, 8'h3C);
        idle(BLC); pulse_done();
        // R12: end-of-cycle pulse outside busy is ignored
        cur_req = "R12";
        pulse_done(); unlock(1); wr(13'h1E00, 8'hF0); pulse_done(); wr(13'h1E3F, 8'h0F);
        idle(1);
        chk(store_o == 1'b1, "R12", store_o, 1);
        idle(BLC); pulse_done(); idle(2);

        // Random mix, checked every cycle against the model
        cur_req = "R3";
        for (int n = 0; n < 400; n++) begin
            int sc;
            sc = $urandom % 6;
            case (sc)
                0, 1: begin
                    logic [6:0] pg;
                    int g;
                    g = 1 + ($urandom % (BLC + 2));
                    pg = 7'($urandom);
                    unlock((g > BLC + 1) ? BLC : g);
                    for (int k = 0; k < 1 + int'($urandom % 5); k++) begin
                        idle($urandom % 3);
                        wr({pg, 6'($urandom)}, 8'($urandom));
                    end
                    if ($urandom % 3 == 0) wr({~pg, 6'd0}, 8'($urandom));
                end
                2: wr(13'($urandom), 8'($urandom));
                3: begin
                    wr(13'h1555, 8'hAA);
                    if ($urandom % 2 == 0) wr(13'h0AAA, 8'($urandom));
                end
                4: for (int k = 0; k < int'($urandom % (BLC + 3)); k++)
                       tick(1'b0, '0, '0, ($urandom % 8) == 0);
                default: pulse_done();
            endcase
        end
        idle(BLC + 2); pulse_done(); idle(2);
        finish_run();
    end

endmodule